// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address into a real address by searching a hashed page table. The table sits in an external memory that the block reaches through a simple request/acknowledge port. That port carries 32-bit reads and single-byte writes. For each walk the caller supplies the segment attributes: a 24-bit virtual segment identifier, a supervisor key, a user key and a segment no-execute flag. The caller also gives the effective address, the access kind (load, store or fetch), the problem-state flag, and a table base with a table mask.

A walk first searches the primary entry group, which the hash selects. If no entry there matches, it searches the secondary group, which the complemented hash selects. On a match the block reads the second word of the entry and checks the access against the protection field and the key. It then records the access in the entry by setting the referenced and changed flags with single-byte writes. Finally it returns the real address and a permission set. A walk that finds no entry, or that is refused, returns a fault code instead.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are 0.
- R2: The page index is `ea[27:12]` and the hash is VSID XOR page index. The primary group address is `cfg_base + ((hash << 6) & cfg_mask)`. Groups hold 8 entries of 8 bytes, and the entries are scanned in slot order. Entry word 0 is at byte offset 0 and word 1 at offset 4. Word 0 of an entry is always read before its word 1, and word 1 is read only for a matching entry.
- R3: An entry matches when all of the following hold: word 0 bit 31 (valid) is 1; word 0 bit 6 equals the search pass (0 primary, 1 secondary); word 0 bits 30:7 equal the VSID; and word 0 bits 5:0 equal `ea[27:22]`.
- R4: When the primary group has no match, the secondary group is searched at `cfg_base + ((~hash << 6) & cfg_mask)`.
- R5: When no entry matches in either group, `fault` is 1 and `fault_code` is as follows: `32'h4000_0000` for a load (`acc`=0) or a fetch (`acc`=2), and `32'h4200_0000` for a store (`acc`=1).
- R6: The key is `key_user` when `prob_state` is 1, otherwise `key_sup`. Read/write rights come from the word 1 bits 1:0 protection value as follows. With key 0, values 0, 1 and 2 give read+write and value 3 gives read. With key 1, value 0 gives nothing, values 1 and 3 give read, and value 2 gives read+write. `perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R7: Execute is granted exactly when `seg_nx` is 0, whatever the protection value.
- R8: An access lacking its right (load needs read, store needs write, fetch needs execute) faults. The code is `32'h0800_0000` for a load or fetch and `32'h0A00_0000` for a store. A refused walk writes nothing to memory.
- R9: On a granted walk whose entry has word 1 bit 8 (referenced) clear, the block writes byte offset 6 of the entry with word 1 bits 15:8 ORed with 8'h01. Bytes are big-endian within a word.
- R10: On a granted store whose entry has word 1 bit 7 (changed) clear, the block writes byte offset 7 of the entry with word 1 bits 7:0 ORed with 8'h80. No changed-flag write happens for loads or fetches.
- R11: When the changed flag is clear and the access is not a store, the write right is removed from `perm`.
- R12: A granted walk returns `real_addr = {word1[31:12], ea[11:0]}`.
- R13: `done` is a single-cycle pulse. When `fault` is 1, `perm` and `real_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| seg_vsid | input | 24 | Virtual segment identifier |
| key_sup | input | 1 | Key used in supervisor state |
| key_user | input | 1 | Key used in problem state |
| seg_nx | input | 1 | Segment no-execute |
| prob_state | input | 1 | Problem (user) state |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| ea | input | 32 | Effective address |
| cfg_base | input | 32 | Table base, 64-byte aligned |
| cfg_mask | input | 32 | Table offset mask |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a byte write, 0 for a word read |
| mem_addr | output | 32 | Byte address |
| mem_wbyte | output | 8 | Write byte |
| mem_ack | input | 1 | Request complete; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk faulted |
| fault_code | output | 32 | Fault code |
| real_addr | output | 32 | Translated real address |
| perm | output | 3 | Granted rights {execute, write, read} |

## Verification
A walk's results all appear in the same cycle as `done`. That cycle is one register stage after the final memory acknowledge, or after the check stage when the walk faults or needs no flag write. Its timing depends on how many entries are scanned, so each scenario task waits for `done` on the falling edge and samples `fault`, `fault_code`, `perm` and `real_addr` in that cycle. The bench checks `done` low one cycle later. Its memory model records every read and write address as the acknowledge is given. Once `done` has been seen, the bench compares those logs and the updated table bytes against addresses it computes itself from the hash formula.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [31:0] CODE_MISS_LD = 32'h4000_0000;
  localparam logic [31:0] CODE_MISS_ST = 32'h4200_0000;
  localparam logic [31:0] CODE_PROT_LD = 32'h0800_0000;
  localparam logic [31:0] CODE_PROT_ST = 32'h0A00_0000;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_RD0, S_RD1, S_CHK, S_WR_R, S_WR_C
  } walk_st_t;

  // Rights as {exec, write, read}
  function automatic logic [1:0] pp_rw(input logic key, input logic [1:0] pp);
    if (!key) pp_rw = (pp == 2'd3) ? 2'b01 : 2'b11;
    else begin
      case (pp)
        2'd0:    pp_rw = 2'b00;
        2'd2:    pp_rw = 2'b11;
        default: pp_rw = 2'b01;
      endcase
    end
  endfunction

  function automatic logic [31:0] miss_code(input logic [1:0] a);
    miss_code = (a == ACC_STORE) ? CODE_MISS_ST : CODE_MISS_LD;
  endfunction
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr
  import hpt_pkg::*;
#(
  parameter int GROUP_BYTES = 64
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] page_idx,
  input  logic              second,
  input  logic [31:0]       base,
  input  logic [31:0]       mask,
  output logic [31:0]       grp_addr
);
  localparam int GSHIFT = $clog2(GROUP_BYTES);

  logic [31:0] hash;
  logic [31:0] sel_hash;

  always_comb begin
    hash     = 32'(vsid) ^ 32'(page_idx);
    sel_hash = second ? ~hash : hash;
    grp_addr = base + ((sel_hash << GSHIFT) & mask);
  end
endmodule

// File: rtl/hpt_access_check.sv
module hpt_access_check
  import hpt_pkg::*;
(
  input  logic [31:0] pte1,
  input  logic        key_sup,
  input  logic        key_user,
  input  logic        prob_state,
  input  logic        seg_nx,
  input  logic [1:0]  acc,
  output logic        allowed,
  output logic [2:0]  perm_out,
  output logic [31:0] viol_code
);
  logic       key;
  logic [2:0] raw;
  logic       need_ok;

  always_comb begin
    key = prob_state ? key_user : key_sup;
    raw = {~seg_nx, pp_rw(key, pte1[1:0])};
    case (acc)
      ACC_STORE: need_ok = raw[1];
      ACC_FETCH: need_ok = raw[2];
      default:   need_ok = raw[0];
    endcase
    allowed   = need_ok;
    perm_out  = (!pte1[7] && acc != ACC_STORE) ? (raw & 3'b101) : raw;
    viol_code = (acc == ACC_STORE) ? CODE_PROT_ST : CODE_PROT_LD;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [23:0]       seg_vsid,
  input  logic              key_sup,
  input  logic              key_user,
  input  logic              seg_nx,
  input  logic              prob_state,
  input  logic [1:0]        acc,
  input  logic [31:0]       ea,
  input  logic [31:0]       cfg_base,
  input  logic [31:0]       cfg_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [7:0]        mem_wbyte,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [31:0]       fault_code,
  output logic [31:0]       real_addr,
  output logic [2:0]        perm
);
  localparam int GROUP_BYTES = GROUP_ENTRIES * ENTRY_BYTES;
  localparam int SLOT_W      = $clog2(GROUP_ENTRIES);
  localparam int ESHIFT      = $clog2(ENTRY_BYTES);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

  walk_st_t          state;
  logic [VSID_W-1:0] vsid_q;
  logic [31:0]       ea_q, base_q, mask_q, pte1_q;
  logic [1:0]        acc_q;
  logic              ks_q, kp_q, nx_q, pr_q, pass_q;
  logic [SLOT_W-1:0] slot_q;

  logic [31:0] grp_addr, entry_addr;
  logic        hit0, allowed;
  logic [2:0]  perm_ok;
  logic [31:0] viol_code;
  logic        need_c;

  hpt_group_addr #(.GROUP_BYTES(GROUP_BYTES)) u_grp (
    .vsid(vsid_q), .page_idx(ea_q[27:12]), .second(pass_q),
    .base(base_q), .mask(mask_q), .grp_addr(grp_addr)
  );

  hpt_access_check u_chk (
    .pte1(pte1_q), .key_sup(ks_q), .key_user(kp_q), .prob_state(pr_q),
    .seg_nx(nx_q), .acc(acc_q), .allowed(allowed), .perm_out(perm_ok),
    .viol_code(viol_code)
  );

  always_comb begin
    entry_addr = grp_addr + (32'(slot_q) << ESHIFT);
    hit0 = mem_rdata[31] && (mem_rdata[6] == pass_q) &&
           (mem_rdata[30:7] == vsid_q) && (mem_rdata[5:0] == ea_q[27:22]);
    need_c = !pte1_q[7] && (acc_q == ACC_STORE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wbyte <= '0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0; real_addr <= '0; perm <= '0;
      vsid_q <= '0; ea_q <= '0; base_q <= '0; mask_q <= '0; pte1_q <= '0;
      acc_q <= '0; ks_q <= 1'b0; kp_q <= 1'b0; nx_q <= 1'b0; pr_q <= 1'b0;
      pass_q <= 1'b0; slot_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          vsid_q <= seg_vsid; ea_q <= ea; base_q <= cfg_base; mask_q <= cfg_mask;
          acc_q <= acc; ks_q <= key_sup; kp_q <= key_user; nx_q <= seg_nx;
          pr_q <= prob_state; pass_q <= 1'b0; slot_q <= '0;
          state <= S_LOOK;
        end
        S_LOOK: begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= entry_addr;
          state <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (hit0) begin
            mem_addr <= entry_addr + 32'd4;
            state <= S_RD1;
          end else begin
            mem_req <= 1'b0;
            if (slot_q != LAST_SLOT) begin
              slot_q <= slot_q + 1'b1; state <= S_LOOK;
            end else if (!pass_q) begin
              pass_q <= 1'b1; slot_q <= '0; state <= S_LOOK;
            end else begin
              done <= 1'b1; fault <= 1'b1; fault_code <= miss_code(acc_q);
              perm <= '0; real_addr <= '0; state <= S_IDLE;
            end
          end
        end
        S_RD1: if (mem_ack) begin
          pte1_q <= mem_rdata; mem_req <= 1'b0; state <= S_CHK;
        end
        S_CHK: begin
          if (!allowed) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= viol_code;
            perm <= '0; real_addr <= '0; state <= S_IDLE;
          end else if (!pte1_q[8]) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= entry_addr + 32'd6;
            mem_wbyte <= pte1_q[15:8] | 8'h01; state <= S_WR_R;
          end else if (need_c) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= entry_addr + 32'd7;
            mem_wbyte <= pte1_q[7:0] | 8'h80; state <= S_WR_C;
          end else begin
            done <= 1'b1; fault <= 1'b0; fault_code <= '0; perm <= perm_ok;
            real_addr <= {pte1_q[31:12], ea_q[11:0]}; state <= S_IDLE;
          end
        end
        S_WR_R: if (mem_ack) begin
          if (need_c) begin
            mem_addr <= entry_addr + 32'd7;
            mem_wbyte <= pte1_q[7:0] | 8'h80; state <= S_WR_C;
          end else begin
            mem_req <= 1'b0; mem_we <= 1'b0;
            done <= 1'b1; fault <= 1'b0; fault_code <= '0; perm <= perm_ok;
            real_addr <= {pte1_q[31:12], ea_q[11:0]}; state <= S_IDLE;
          end
        end
        S_WR_C: if (mem_ack) begin
          mem_req <= 1'b0; mem_we <= 1'b0;
          done <= 1'b1; fault <= 1'b0; fault_code <= '0; perm <= perm_ok;
          real_addr <= {pte1_q[31:12], ea_q[11:0]}; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a pending request keeps its address and kind until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: the second-word read only follows a first-word read
  p_word_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD1) |-> ($past(state) == S_RD0 || $past(state) == S_RD1));

  // R9: referenced-flag byte always carries bit 0 set
  p_ref_byte_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr[2:0] == 3'd6) |-> mem_wbyte[0]);

  // R10: changed-flag byte carries bit 7 and only for stores
  p_chg_byte_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr[2:0] == 3'd7) |-> (mem_wbyte[7] && acc_q == ACC_STORE));

  // R13: done is a single-cycle pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13: a fault returns no rights and no address
  p_fault_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (perm == 3'b000 && real_addr == 32'd0));
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] MASK = 32'h0000_0FC0;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] seg_vsid = '0;
  logic key_sup = 0, key_user = 0, seg_nx = 0, prob_state = 0;
  logic [1:0] acc = 0;
  logic [31:0] ea = 0, cfg_base = BASE, cfg_mask = MASK;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [7:0] mem_wbyte;
  logic done, fault;
  logic [31:0] fault_code, real_addr;
  logic [2:0] perm;

  logic [31:0] mem [0:2047];
  logic [31:0] rd_log [0:63];
  int rd_cnt, wr_cnt;
  logic [31:0] wr_last;
  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst(rst), .start(start), .seg_vsid(seg_vsid), .key_sup(key_sup),
    .key_user(key_user), .seg_nx(seg_nx), .prob_state(prob_state), .acc(acc),
    .ea(ea), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wbyte(mem_wbyte), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .fault_code(fault_code),
    .real_addr(real_addr), .perm(perm)
  );

  // Memory model: one acknowledge per request, big-endian byte lanes
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]][31-8*mem_addr[1:0] -: 8] <= mem_wbyte;
        wr_cnt <= wr_cnt + 1; wr_last <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        if (rd_cnt < 64) rd_log[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] e, input logic sec);
    logic [31:0] h;
    h = {8'd0, v} ^ {16'd0, e[27:12]};
    if (sec) h = ~h;
    return BASE + ((h << 6) & MASK);
  endfunction

  function automatic logic [31:0] w0(input logic [23:0] v, input logic [31:0] e, input logic hsel);
    return {1'b1, v, hsel, e[27:22]};
  endfunction

  function automatic logic [31:0] w1(input logic [19:0] rpn, input logic r, input logic c, input logic [1:0] pp);
    return {rpn, 3'b000, r, c, 5'b00000, pp};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 32'd0;
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d0, input logic [31:0] d1);
    mem[a[12:2]] = d0;
    mem[a[12:2] + 11'd1] = d1;
  endtask

  task automatic walk(input logic [23:0] v, input logic ks, input logic kp, input logic nx,
                      input logic pr, input logic [1:0] a, input logic [31:0] e);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    seg_vsid = v; key_sup = ks; key_user = kp; seg_nx = nx; prob_state = pr;
    acc = a; ea = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 fault", {31'd0, fault}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_primary_hit();
    logic [23:0] v = 24'h000123;
    logic [31:0] e = 32'h0345_6ABC;
    logic [31:0] g = grp(v, e, 1'b0);
    clear_mem();
    put(g + 32'd16, w0(v, e, 1'b0), w1(20'hABCDE, 1'b0, 1'b0, 2'd2));
    walk(v, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, e);
    check("R12 primary real_addr", real_addr, 32'hABCD_EABC);
    check("R11 load C clear drops W", {29'd0, perm}, 32'd5);
    check("R2 first read is group base", rd_log[0], g);
    check("R2 next entry stride", rd_log[1], g + 32'd8);
    check("R2 word1 after word0", rd_log[3], g + 32'd20);
    check("R2 read count", rd_cnt, 32'd4);
    @(negedge clk);
    check("R13 done pulse", {31'd0, done}, 32'd0);
    check("R9 one write", wr_cnt, 32'd1);
    check("R9 ref byte addr", wr_last, g + 32'd22);
    check("R9 ref flag set", mem[(g + 32'd20) >> 2 & 32'h7FF], w1(20'hABCDE, 1'b1, 1'b0, 2'd2));
  endtask

  task automatic t_secondary_hit();
    logic [23:0] v = 24'h0ABCDE;
    logic [31:0] e = 32'h1234_5678;
    logic [31:0] g0 = grp(v, e, 1'b0);
    logic [31:0] g1 = grp(v, e, 1'b1);
    clear_mem();
    put(g0, w0(v, e, 1'b1), w1(20'h11111, 1'b1, 1'b1, 2'd2));
    put(g1, w0(v, e, 1'b0), w1(20'h22222, 1'b1, 1'b1, 2'd2));
    put(g1 + 32'd40, w0(v, e, 1'b1), w1(20'h33333, 1'b1, 1'b0, 2'd1));
    walk(v, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, e);
    check("R4 secondary fault", {31'd0, fault}, 32'd0);
    check("R4 secondary group addr", rd_log[8], g1);
    check("R3 hash-select skips", rd_cnt, 32'd15);
    check("R6 user key 0 store perm", {29'd0, perm}, 32'd7);
    check("R12 secondary real_addr", real_addr, 32'h3333_3678);
    @(negedge clk);
    check("R10 one write", wr_cnt, 32'd1);
    check("R10 chg byte addr", wr_last, g1 + 32'd47);
    check("R10 chg flag set", mem[(g1 + 32'd44) >> 2 & 32'h7FF], w1(20'h33333, 1'b1, 1'b1, 2'd1));
  endtask

  task automatic t_miss();
    logic [23:0] v = 24'h00F00D;
    logic [31:0] e = 32'h0765_4321;
    clear_mem();
    walk(v, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, e);
    check("R5 load miss", fault_code, 32'h4000_0000);
    check("R5 load miss fault", {31'd0, fault}, 32'd1);
    check("R13 fault perm zero", {29'd0, perm}, 32'd0);
    check("R5 all entries read", rd_cnt, 32'd16);
    walk(v, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, e);
    check("R5 store miss", fault_code, 32'h4200_0000);
    walk(v, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, e);
    check("R5 fetch miss", fault_code, 32'h4000_0000);
    @(negedge clk);
    check("R5 no writes", wr_cnt, 32'd0);
  endtask

  task automatic t_tag_mismatch();
    logic [23:0] v = 24'h000777;
    logic [31:0] e = 32'h0040_1000;
    logic [31:0] g = grp(v, e, 1'b0);
    clear_mem();
    put(g, w0(v, e, 1'b0) ^ 32'h0000_0001, w1(20'h44444, 1'b1, 1'b1, 2'd2));
    put(g + 32'd8, w0(v, e, 1'b0) & 32'h7FFF_FFFF, w1(20'h44444, 1'b1, 1'b1, 2'd2));
    walk(v, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, e);
    check("R3 tag/valid mismatch misses", fault_code, 32'h4000_0000);
  endtask

  task automatic t_violations();
    logic [23:0] v = 24'h005555;
    logic [31:0] e = 32'h0ABC_D123;
    logic [31:0] g = grp(v, e, 1'b0);
    clear_mem();
    put(g, w0(v, e, 1'b0), w1(20'h55555, 1'b0, 1'b0, 2'd1));
    walk(v, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, e);
    check("R8 store violation code", fault_code, 32'h0A00_0000);
    check("R13 fault addr zero", real_addr, 32'd0);
    @(negedge clk);
    check("R8 no write on refusal", wr_cnt, 32'd0);
    check("R8 entry untouched", mem[(g + 32'd4) >> 2 & 32'h7FF], w1(20'h55555, 1'b0, 1'b0, 2'd1));
    put(g, w0(v, e, 1'b0), w1(20'h55555, 1'b1, 1'b1, 2'd0));
    walk(v, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, e);
    check("R8 load violation code", fault_code, 32'h0800_0000);
    put(g, w0(v, e, 1'b0), w1(20'h55555, 1'b1, 1'b1, 2'd2));
    walk(v, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, e);
    check("R7 nx fetch refused", fault_code, 32'h0800_0000);
  endtask

  task automatic t_perms();
    logic [23:0] v = 24'h0C0FFE;
    logic [31:0] e = 32'h0F00_0FFF;
    logic [31:0] g = grp(v, e, 1'b0);
    clear_mem();
    put(g, w0(v, e, 1'b0), w1(20'h66666, 1'b1, 1'b1, 2'd3));
    walk(v, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, e);
    check("R6 key0 pp3 read only", {29'd0, perm}, 32'd5);
    walk(v, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, e);
    check("R6 key1 pp3 read only", {29'd0, perm}, 32'd5);
    put(g, w0(v, e, 1'b0), w1(20'h66666, 1'b1, 1'b1, 2'd2));
    walk(v, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, e);
    check("R7 nx removes exec", {29'd0, perm}, 32'd3);
    put(g, w0(v, e, 1'b0), w1(20'h66666, 1'b1, 1'b1, 2'd0));
    walk(v, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, e);
    check("R7 exec without read", {29'd0, perm}, 32'd4);
    check("R7 fetch granted", {31'd0, fault}, 32'd0);
    put(g, w0(v, e, 1'b0), w1(20'h66666, 1'b1, 1'b0, 2'd0));
    walk(v, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, e);
    check("R11 fetch C clear drops W", {29'd0, perm}, 32'd5);
    @(negedge clk);
    check("R10 no C write on fetch", wr_cnt, 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rd_cnt = 0; wr_cnt = 0; wr_last = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_primary_hit();
    t_secondary_hit();
    t_miss();
    t_tag_mismatch();
    t_violations();
    t_perms();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule